// File: doc/BRIEF.md
# Register-Free Staged ALU Array

This block is a clockless grid of ALUs arranged as a chain of stages. Each stage holds a fixed number of ALU slots. All slots in a stage read from one shared bundle of W-bit lines and write back onto that bundle. The bundle a stage writes becomes the bundle the next stage reads. Nothing in the array is clocked: a value placed on the input lines ripples through every stage and settles on the per-stage output lines within the same cycle. An external operand-forwarding matrix captures those output lines and can feed them back.

A configuration word per slot is held steady for the whole accelerated routine. It selects an opcode, two source lines, a destination line and a predicate flag. Only the first slot of a stage can resolve a compare-and-branch, and it raises that stage's taken flag. Only the last slot of a stage can reach memory, through a combinational port to an outside memory model.

A taken flag in any earlier stage mutes every later slot whose predicate flag is set. This lets a short forward branch be flattened into straight-line code. The house state-machine layout has no state to hold here, so the design is purely combinational and keeps only the naming and layout conventions.

Top module: `stalu_array`

## Requirements
- R1: The array has no clock and no storage. Every output depends only on the present values of `cfg_i`, `lines_i` and `mem_rdata_i`.
- R2: A slot configuration word is packed LSB first as:
  - opcode[3:0]
  - source A index (LW bits)
  - source B index (LW bits)
  - destination index (LW bits)
  - predicate flag (top bit)
  
  LW is clog2(LINES). Slot j of stage s sits at word index s*SLOTS+j.
- R3: The opcodes are:
  - 0 no-op
  - 1 A+B
  - 2 A-B
  - 3 A&B
  - 4 A|B
  - 5 A^B
  - 6 A<<B
  - 7 logical A>>B
  - 8 arithmetic A>>B
  - 9 signed A<B giving 1 or 0
  - 10 copy A
  - 11 branch-if-equal
  - 12 branch-if-not-equal
  - 13 branch-if-signed-less
  - 14 load
  - 15 store
  
  Shift amounts use the low clog2(W) bits of B. Opcodes 1 to 10 write their result to the destination line.
- R4: Stage 0 reads `lines_i`. Stage s>0 reads the output lines of stage s-1, so a dependent instruction in a later stage sees an earlier result.
- R5: The branch opcodes 11 to 13 act only in slot 0. They set `taken_o[s]` when the compare holds, write no line, and behave as a no-op in any other slot.
- R6: Load and store act only in the last slot. In that slot, `mem_addr_o[s]` is line A and `mem_wdata_o[s]` is line B. A store raises `mem_we_o[s]`. A load writes `mem_rdata_i[s]` to the destination line. In any other slot both are no-ops.
- R7: A line written by no slot leaves the stage unchanged, and a no-op writes nothing.
- R8: A slot with its predicate flag set is muted when any earlier stage's taken flag is set. A muted slot writes no line (the line keeps its incoming value), raises no store enable and sets no taken flag. An unpredicated slot is never muted.
- R9: When several slots in a stage name the same destination line, the highest-numbered slot's result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_i | input | STAGES*SLOTS*CW | Static slot configuration words |
| lines_i | input | LINES*W | Operand lines entering stage 0 |
| mem_rdata_i | input | STAGES*W | Load data returned per stage |
| lines_o | output | STAGES*LINES*W | Output line bundle of every stage |
| taken_o | output | STAGES | Branch outcome per stage |
| mem_we_o | output | STAGES | Store enable per stage |
| mem_addr_o | output | STAGES*W | Memory address per stage |
| mem_wdata_o | output | STAGES*W | Store data per stage |

## Verification
The bench sweeps every arithmetic opcode over operand pairs that cross the sign boundary and use all shift amounts. A wrong signed compare or arithmetic shift would show up here as a mismatch on the negative half.

It places branch and memory opcodes in forbidden slots. A design that ignored the slot roles would raise a taken flag, write a line or strobe a store where none is allowed.

It runs a taken branch against predicated and unpredicated slots in the next stage. A design that muted too much or too little would clobber or freeze the wrong lines.

Finally, it stacks three writers on one line and chains a dependent result across stages, which catches reversed priority and broken stage chaining.

// File: rtl/stalu_pkg.sv
package stalu_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_SLL   = 4'd6,
        OP_SRL   = 4'd7,
        OP_SRA   = 4'd8,
        OP_SLT   = 4'd9,
        OP_MOV   = 4'd10,
        OP_BEQ   = 4'd11,
        OP_BNE   = 4'd12,
        OP_BLT   = 4'd13,
        OP_LOAD  = 4'd14,
        OP_STORE = 4'd15
    } stalu_op_e;
endpackage

// File: rtl/stalu_slot.sv
module stalu_slot
    import stalu_pkg::*;
#(
    parameter int W        = 32,
    parameter int LINES    = 8,
    parameter bit IS_FIRST = 1'b0,
    parameter bit IS_LAST  = 1'b0,
    localparam int LW      = $clog2(LINES),
    localparam int CW      = OPW + 3*LW + 1
) (
    input  logic [CW-1:0]      cfg_i,
    input  logic [LINES*W-1:0] lines_i,
    input  logic               skip_i,
    input  logic [W-1:0]       rdata_i,
    output logic               wr_o,
    output logic [LW-1:0]      wr_idx_o,
    output logic [W-1:0]       wr_val_o,
    output logic               br_o,
    output logic               we_o,
    output logic [W-1:0]       addr_o,
    output logic [W-1:0]       wdata_o
);
    localparam int SHW = $clog2(W);

    stalu_op_e      op;
    logic [LW-1:0]  sel_a, sel_b;
    logic           pred;
    logic [W-1:0]   opa, opb;
    logic [SHW-1:0] sh;
    logic           muted;

    assign op       = stalu_op_e'(cfg_i[OPW-1:0]);
    assign sel_a    = cfg_i[OPW +: LW];
    assign sel_b    = cfg_i[OPW+LW +: LW];
    assign wr_idx_o = cfg_i[OPW+2*LW +: LW];
    assign pred     = cfg_i[CW-1];
    assign opa      = lines_i[sel_a*W +: W];
    assign opb      = lines_i[sel_b*W +: W];
    assign sh       = opb[SHW-1:0];
    assign muted    = pred && skip_i;

    always_comb begin
        wr_o     = 1'b0;
        wr_val_o = '0;
        br_o     = 1'b0;
        we_o     = 1'b0;
        addr_o   = IS_LAST ? opa : '0;
        wdata_o  = IS_LAST ? opb : '0;
        case (op)
            OP_ADD: begin wr_o = 1'b1; wr_val_o = opa + opb; end
            OP_SUB: begin wr_o = 1'b1; wr_val_o = opa - opb; end
            OP_AND: begin wr_o = 1'b1; wr_val_o = opa & opb; end
            OP_OR:  begin wr_o = 1'b1; wr_val_o = opa | opb; end
            OP_XOR: begin wr_o = 1'b1; wr_val_o = opa ^ opb; end
            OP_SLL: begin wr_o = 1'b1; wr_val_o = opa << sh; end
            OP_SRL: begin wr_o = 1'b1; wr_val_o = opa >> sh; end
            OP_SRA: begin wr_o = 1'b1; wr_val_o = $unsigned($signed(opa) >>> sh); end
            OP_SLT: begin
                wr_o     = 1'b1;
                wr_val_o = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            end
            OP_MOV: begin wr_o = 1'b1; wr_val_o = opa; end
            OP_BEQ: br_o = IS_FIRST && (opa == opb);
            OP_BNE: br_o = IS_FIRST && (opa != opb);
            OP_BLT: br_o = IS_FIRST && ($signed(opa) < $signed(opb));
            OP_LOAD: begin
                wr_o     = IS_LAST;
                wr_val_o = IS_LAST ? rdata_i : '0;
            end
            OP_STORE: we_o = IS_LAST;
            default: ;
        endcase
        if (muted) begin
            wr_o = 1'b0;
            br_o = 1'b0;
            we_o = 1'b0;
        end
    end
endmodule

// File: rtl/stalu_stage.sv
module stalu_stage
    import stalu_pkg::*;
#(
    parameter int W     = 32,
    parameter int LINES = 8,
    parameter int SLOTS = 5,
    localparam int LW   = $clog2(LINES),
    localparam int CW   = OPW + 3*LW + 1
) (
    input  logic [SLOTS*CW-1:0] cfg_i,
    input  logic [LINES*W-1:0]  lines_i,
    input  logic                skip_i,
    input  logic [W-1:0]        rdata_i,
    output logic [LINES*W-1:0]  lines_o,
    output logic                taken_o,
    output logic                we_o,
    output logic [W-1:0]        addr_o,
    output logic [W-1:0]        wdata_o
);
    logic [SLOTS-1:0] wr_s, br_s, we_s;
    logic [LW-1:0]    idx_s   [SLOTS];
    logic [W-1:0]     val_s   [SLOTS];
    logic [W-1:0]     addr_s  [SLOTS];
    logic [W-1:0]     wdata_s [SLOTS];

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        stalu_slot #(
            .W(W), .LINES(LINES),
            .IS_FIRST(j == 0), .IS_LAST(j == SLOTS-1)
        ) u_slot (
            .cfg_i   (cfg_i[j*CW +: CW]),
            .lines_i (lines_i),
            .skip_i  (skip_i),
            .rdata_i (rdata_i),
            .wr_o    (wr_s[j]),
            .wr_idx_o(idx_s[j]),
            .wr_val_o(val_s[j]),
            .br_o    (br_s[j]),
            .we_o    (we_s[j]),
            .addr_o  (addr_s[j]),
            .wdata_o (wdata_s[j])
        );
    end

    // Later slots override earlier ones on a shared destination line.
    always_comb begin
        lines_o = lines_i;
        for (int j = 0; j < SLOTS; j++) begin
            if (wr_s[j]) lines_o[idx_s[j]*W +: W] = val_s[j];
        end
    end

    always_comb begin
        addr_o  = '0;
        wdata_o = '0;
        for (int j = 0; j < SLOTS; j++) begin
            addr_o  = addr_o  | addr_s[j];
            wdata_o = wdata_o | wdata_s[j];
        end
    end

    assign taken_o = |br_s;
    assign we_o    = |we_s;

    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            logic hit;
            hit = 1'b0;
            for (int j = 0; j < SLOTS; j++) begin
                if (wr_s[j] && (idx_s[j] == LW'(l))) hit = 1'b1;
            end
            if (!hit) begin
                assert_line_hold_R7: assert (lines_o[l*W +: W] == lines_i[l*W +: W]);
            end
        end
        if (taken_o) begin
            assert_branch_slot_R5: assert (cfg_i[OPW-1:0] inside {OP_BEQ, OP_BNE, OP_BLT});
        end
        if (we_o) begin
            assert_store_slot_R6: assert (cfg_i[(SLOTS-1)*CW +: OPW] == OP_STORE);
        end
        for (int j = 0; j < SLOTS; j++) begin
            if (skip_i && cfg_i[j*CW + CW-1]) begin
                assert_pred_mute_R8: assert (!wr_s[j] && !br_s[j] && !we_s[j]);
            end
        end
    end
endmodule

// File: rtl/stalu_array.sv
module stalu_array
    import stalu_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int SLOTS  = 5,
    parameter int LINES  = 8,
    parameter int W      = 32,
    localparam int LW    = $clog2(LINES),
    localparam int CW    = OPW + 3*LW + 1,
    localparam int LBW   = LINES * W
) (
    input  logic [STAGES*SLOTS*CW-1:0] cfg_i,
    input  logic [LBW-1:0]             lines_i,
    input  logic [STAGES*W-1:0]        mem_rdata_i,
    output logic [STAGES*LBW-1:0]      lines_o,
    output logic [STAGES-1:0]          taken_o,
    output logic [STAGES-1:0]          mem_we_o,
    output logic [STAGES*W-1:0]        mem_addr_o,
    output logic [STAGES*W-1:0]        mem_wdata_o
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [LBW-1:0] src;
        logic           skip;

        if (s == 0) begin : g_head
            assign src  = lines_i;
            assign skip = 1'b0;
        end else begin : g_body
            assign src  = lines_o[(s-1)*LBW +: LBW];
            assign skip = |taken_o[s-1:0];
        end

        stalu_stage #(.W(W), .LINES(LINES), .SLOTS(SLOTS)) u_stage (
            .cfg_i   (cfg_i[s*SLOTS*CW +: SLOTS*CW]),
            .lines_i (src),
            .skip_i  (skip),
            .rdata_i (mem_rdata_i[s*W +: W]),
            .lines_o (lines_o[s*LBW +: LBW]),
            .taken_o (taken_o[s]),
            .we_o    (mem_we_o[s]),
            .addr_o  (mem_addr_o[s*W +: W]),
            .wdata_o (mem_wdata_o[s*W +: W])
        );
    end
endmodule

// File: tb/stalu_array_bench.sv
module stalu_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ST = 2;
    localparam int SL = 3;
    localparam int LN = 4;
    localparam int W  = 8;
    localparam int LW = 2;
    localparam int CW = 4 + 3*LW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [CW-1:0]        cfg_a [ST][SL];
    logic [ST*SL*CW-1:0]  cfg_flat;
    logic [LN*W-1:0]      lines_in;
    logic [ST*W-1:0]      rdata;
    logic [ST*LN*W-1:0]   lines_out;
    logic [ST-1:0]        taken, mem_we;
    logic [ST*W-1:0]      mem_addr, mem_wdata;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always_comb begin
        for (int s = 0; s < ST; s++)
            for (int j = 0; j < SL; j++)
                cfg_flat[(s*SL+j)*CW +: CW] = cfg_a[s][j];
    end

    stalu_array #(.STAGES(ST), .SLOTS(SL), .LINES(LN), .W(W)) u_stalu_array (
        .cfg_i      (cfg_flat),
        .lines_i    (lines_in),
        .mem_rdata_i(rdata),
        .lines_o    (lines_out),
        .taken_o    (taken),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_wdata_o(mem_wdata)
    );

    function automatic logic [CW-1:0] mk(int op, int a, int b, int d, bit p);
        return {p, LW'(d), LW'(b), LW'(a), 4'(op)};
    endfunction

    function automatic logic [W-1:0] ln(int s, int l);
        return lines_out[(s*LN+l)*W +: W];
    endfunction

    function automatic logic [W-1:0] ref_alu(int op, logic [W-1:0] a, logic [W-1:0] b);
        int sh, sa, sb, r;
        sh = int'(b % 8);
        sa = (a >= 128) ? int'(a) - 256 : int'(a);
        sb = (b >= 128) ? int'(b) - 256 : int'(b);
        case (op)
            1: r = int'(a) + int'(b);
            2: r = int'(a) - int'(b);
            3: r = int'(a & b);
            4: r = int'(a | b);
            5: r = int'(a ^ b);
            6: r = int'(a) * (2 ** sh);
            7: r = int'(a) / (2 ** sh);
            8: r = (sa < 0) ? -((-sa + (2 ** sh) - 1) / (2 ** sh)) : sa / (2 ** sh);
            9: r = (sa < sb) ? 1 : 0;
            default: r = int'(a);
        endcase
        return W'(r & 255);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int s = 0; s < ST; s++)
            for (int j = 0; j < SL; j++)
                cfg_a[s][j] = '0;
    endtask

    task automatic set_lines(int l0, int l1, int l2, int l3);
        lines_in = {W'(l3), W'(l2), W'(l1), W'(l0)};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        clear_cfg();
        set_lines(8'h11, 8'h22, 8'h33, 8'h44);
        rdata = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1 R7: all no-ops, lines pass through both stages
        @(negedge clk);
        for (int s = 0; s < ST; s++)
            for (int l = 0; l < LN; l++)
                chk("R7 idle pass", ln(s, l), lines_in[l*W +: W]);
        chk("R1 idle taken", taken, 0);
        chk("R1 idle we", mem_we, 0);

        // R2 R3 R4: opcode sweep in stage 0 slot 1
        for (int op = 1; op <= 10; op++) begin
            for (int a = 0; a < 256; a += 15) begin
                for (int b = 0; b < 256; b += 17) begin
                    @(posedge clk);
                    clear_cfg();
                    cfg_a[0][1] = mk(op, 0, 1, 2, 1'b0);
                    set_lines(a, b, 8'h5A, 8'hC3);
                    @(negedge clk);
                    chk($sformatf("R3 op%0d a=%0h b=%0h", op, a, b), ln(0, 2), ref_alu(op, W'(a), W'(b)));
                    chk("R7 untouched line", ln(0, 3), 8'hC3);
                    chk("R4 chained stage", ln(1, 2), ref_alu(op, W'(a), W'(b)));
                end
            end
        end

        // R4: dependency across stages
        @(posedge clk);
        clear_cfg();
        cfg_a[0][0] = mk(1, 0, 1, 2, 1'b0);
        cfg_a[1][1] = mk(2, 2, 0, 3, 1'b0);
        set_lines(8'h35, 8'h4C, 0, 0);
        @(negedge clk);
        chk("R4 dependent result", ln(1, 3), 8'h4C);

        // R5: branches in slot 0
        @(posedge clk);
        clear_cfg();
        cfg_a[0][0] = mk(13, 0, 1, 2, 1'b0);
        set_lines(8'h80, 8'h01, 8'h77, 0);
        @(negedge clk);
        chk("R5 blt signed taken", taken, 2'b01);
        chk("R5 branch writes nothing", ln(0, 2), 8'h77);
        @(posedge clk);
        set_lines(8'h01, 8'h80, 8'h77, 0);
        @(negedge clk);
        chk("R5 blt signed not taken", taken, 0);
        @(posedge clk);
        cfg_a[0][0] = mk(12, 0, 1, 2, 1'b0);
        @(negedge clk);
        chk("R5 bne taken", taken, 2'b01);

        // R5: branch outside slot 0 is a no-op
        @(posedge clk);
        clear_cfg();
        cfg_a[0][1] = mk(11, 0, 1, 2, 1'b0);
        set_lines(8'h09, 8'h09, 8'h66, 0);
        @(negedge clk);
        chk("R5 beq slot1 no flag", taken, 0);
        chk("R5 beq slot1 no write", ln(0, 2), 8'h66);

        // R6: memory only in last slot
        @(posedge clk);
        clear_cfg();
        cfg_a[0][0] = mk(15, 0, 1, 2, 1'b0);
        cfg_a[0][1] = mk(14, 0, 1, 3, 1'b0);
        rdata = {8'hE1, 8'hD0};
        set_lines(8'h10, 8'h20, 8'h30, 8'h40);
        @(negedge clk);
        chk("R6 store slot0 no we", mem_we, 0);
        chk("R6 load slot1 no write", ln(0, 3), 8'h40);
        @(posedge clk);
        clear_cfg();
        cfg_a[0][2] = mk(15, 0, 1, 2, 1'b0);
        cfg_a[1][2] = mk(14, 1, 0, 3, 1'b0);
        @(negedge clk);
        chk("R6 store we", mem_we, 2'b01);
        chk("R6 store addr", mem_addr[7:0], 8'h10);
        chk("R6 store data", mem_wdata[7:0], 8'h20);
        chk("R6 load addr", mem_addr[15:8], 8'h20);
        chk("R6 load data", ln(1, 3), 8'hE1);

        // R8: predication after a taken branch
        @(posedge clk);
        clear_cfg();
        cfg_a[0][0] = mk(11, 0, 1, 0, 1'b0);
        cfg_a[1][0] = mk(12, 0, 2, 0, 1'b1);
        cfg_a[1][1] = mk(1, 0, 1, 3, 1'b1);
        cfg_a[1][2] = mk(15, 0, 1, 0, 1'b1);
        set_lines(8'h05, 8'h05, 8'h09, 8'h33);
        @(negedge clk);
        chk("R8 muted taken", taken, 2'b01);
        chk("R8 muted line keeps", ln(1, 3), 8'h33);
        chk("R8 muted store", mem_we, 0);
        @(posedge clk);
        set_lines(8'h05, 8'h06, 8'h09, 8'h33);
        @(negedge clk);
        chk("R8 live taken", taken, 2'b10);
        chk("R8 live add", ln(1, 3), 8'h0B);
        chk("R8 live store", mem_we, 2'b10);
        @(posedge clk);
        set_lines(8'h05, 8'h05, 8'h09, 8'h33);
        cfg_a[1][1] = mk(1, 0, 1, 3, 1'b0);
        @(negedge clk);
        chk("R8 unpredicated runs", ln(1, 3), 8'h0A);

        // R9: highest slot wins a shared destination
        @(posedge clk);
        clear_cfg();
        cfg_a[0][0] = mk(1, 0, 1, 2, 1'b0);
        cfg_a[0][1] = mk(2, 0, 1, 2, 1'b0);
        cfg_a[0][2] = mk(5, 0, 1, 2, 1'b0);
        set_lines(8'hF0, 8'h3C, 0, 0);
        @(negedge clk);
        chk("R9 slot priority", ln(0, 2), 8'hCC);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule